// File: doc/BRIEF.md
# Cascaded LFSR Down-Timer

This block is a programmable cycle timer for designs that need many fast, compact timers. Instead of a binary down-counter, its state is held in a chain of short linear-feedback shift-register segments. Each segment has only a two-input XOR in its feedback path. A loaded start pattern is stepped through the chain's sequence until every segment sits on its fixed terminal pattern. At that point a single-cycle `done` pulse is produced. Host software picks the start pattern that gives the cycle count it wants. Doing that search is outside this block.

The lowest segment advances on every enabled cycle. Each higher segment advances only in a cycle where all segments below it are on their terminal pattern, so the terminal pattern acts as a carry. With the default two segments of 18 bits, the longest run is (2^18-1)^2 steps, which is more than 2^35.

Terminal detection is split over two register stages. Each segment keeps a registered flag marking that it is on its terminal pattern. The pulse is built from those flags one cycle later. As a result, a programmed count of N cycles uses a start pattern that is N-1 steps before the terminal state.

Top module: `seg_lfsr_timer`

## Requirements
- R1: After reset, `done` is low, the timer is idle and every segment holds its terminal pattern. With no load, `done` stays low whatever `en` does.
- R2: Each segment of width `SEG_W` shifts toward its MSB. The bit entering bit 0 is bit `SEG_W-1` XOR bit `TAP-1`; the defaults are 18 and 11. The terminal pattern of every segment is `WRAP_PAT`, by default the value 1.
- R3: `preload[i*SEG_W +: SEG_W]` loads segment i. Segment 0, in the least significant bits, is the one that steps on every enabled cycle.
- R4: Segment i>0 advances exactly once for each enabled step taken while all segments below it hold the terminal pattern. From a start where segment 0 is a steps and segment 1 is b steps before the terminal pattern, the number of steps to terminal is k = a + (2^SEG_W-1)*b.
- R5: With `en` held high, `done` is high in the cycle that follows the (k+1)-th rising edge after the load edge. The shortest legal count is one cycle, which is a preload equal to the terminal state.
- R6: `done` is high for exactly one cycle per count.
- R7: A cycle with `en` low, taken before the terminal state is reached, takes no step and delays `done` by one cycle.
- R8: After `done`, the timer stays idle on its terminal state and gives no further `done` until the next load.
- R9: `load` takes priority over stepping in the same cycle and restarts the count from the new pattern. A load in the cycle that would have set `done` suppresses that pulse.
- R10: A load in the cycle right after `done` starts a new count, timed from that load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Loads `preload` into all segments and starts a count |
| preload | input | SEG_W*SEG_NUM | Start pattern; segment 0 in the LSBs |
| en | input | 1 | Allows one step in this cycle |
| done | output | 1 | One-cycle end-of-count pulse |

## Verification
Counting from the load edge, a start pattern k steps from terminal puts `done` high after edge k+1. Every gap cycle on `en` adds one more edge. The bench drives inputs on falling edges and samples `done` on every falling edge after the load. It records the index of the first edge that shows the pulse and compares it with k+1 plus the gaps, where k comes from the closed form in R4. It also checks that `done` is low right after a load edge and one edge after a pulse. During hold and reset it checks that `done` stays low over a window of several dozen edges.

// File: rtl/seg_lfsr_timer_pkg.sv
package seg_lfsr_timer_pkg;

   // Run state of the timer controller
   typedef enum logic {
      TMR_IDLE = 1'b0,
      TMR_RUN  = 1'b1
   } tmr_state_e;

   // Number of distinct states a maximal segment cycles through
   function automatic longint unsigned seg_period(input int unsigned width);
      return (longint'(1) << width) - 1;
   endfunction

endpackage

// File: rtl/lfsr_seg.sv
module lfsr_seg #(
   parameter int unsigned          SEG_W = 18,
   parameter int unsigned          TAP   = 11,
   parameter logic [SEG_W-1:0]     WRAP  = SEG_W'(1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [SEG_W-1:0] pre_i,
   input  logic             adv_i,
   output logic [SEG_W-1:0] state_o,
   output logic             at_wrap_o
);

   localparam int unsigned MSB = SEG_W - 1;

   if (SEG_W < 3) begin : g_bad_width
      $error("lfsr_seg: SEG_W must be at least 3");
   end
   if (TAP == 0 || TAP >= SEG_W) begin : g_bad_tap
      $error("lfsr_seg: TAP must lie in 1..SEG_W-1");
   end
   if (WRAP == '0) begin : g_bad_wrap
      $error("lfsr_seg: terminal pattern must be nonzero");
   end

   logic [SEG_W-1:0] s_q;
   logic [SEG_W-1:0] s_step;
   logic [SEG_W-1:0] s_d;
   logic             at_q;

   // Two-input feedback keeps the step path one gate deep
   always_comb begin
      s_step = {s_q[MSB-1:0], s_q[MSB] ^ s_q[TAP-1]};
      if (load_i)     s_d = pre_i;
      else if (adv_i) s_d = s_step;
      else            s_d = s_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_q  <= WRAP;
         at_q <= 1'b1;
      end else begin
         s_q  <= s_d;
         at_q <= (s_d == WRAP);
      end
   end

   assign state_o   = s_q;
   assign at_wrap_o = at_q;

   // R7
   seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_i) |=> $stable(s_q));

   // R2
   wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_q == (s_q == WRAP));

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
   import seg_lfsr_timer_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic en_i,
   input  logic term_i,
   output logic step_o,
   output logic done_o
);

   tmr_state_e st_q;
   logic       done_q;
   logic       running;

   assign running = (st_q == TMR_RUN);
   assign step_o  = running && en_i && !term_i && !load_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= TMR_IDLE;
         done_q <= 1'b0;
      end else begin
         done_q <= running && term_i && !load_i;
         if (load_i)
            st_q <= TMR_RUN;
         else if (running && term_i)
            st_q <= TMR_IDLE;
      end
   end

   assign done_o = done_q;

   // R6
   done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R9
   load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> !done_q);

   // R8
   idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == TMR_IDLE && !load_i) |=> !done_q);

endmodule

// File: rtl/seg_lfsr_timer.sv
module seg_lfsr_timer #(
   parameter int unsigned      SEG_W    = 18,
   parameter int unsigned      SEG_NUM  = 2,
   parameter int unsigned      TAP      = 11,
   parameter logic [SEG_W-1:0] WRAP_PAT = SEG_W'(1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [SEG_W*SEG_NUM-1:0]   preload,
   input  logic                       en,
   output logic                       done
);

   localparam int unsigned TOT_W = SEG_W * SEG_NUM;

   if (SEG_NUM < 1) begin : g_bad_num
      $error("seg_lfsr_timer: SEG_NUM must be at least 1");
   end
   if (TOT_W > 256) begin : g_bad_total
      $error("seg_lfsr_timer: total state width too large");
   end

   logic                 step;
   logic                 term;
   logic [SEG_NUM-1:0]   carry;
   logic [SEG_NUM-1:0]   at;
   logic [SEG_W-1:0]     seg_q [SEG_NUM];

   for (genvar i = 0; i < SEG_NUM; i++) begin : g_seg
      if (i == 0) begin : g_base
         assign carry[i] = step;
      end else begin : g_chain
         // one-cycle enable: only while every lower segment is on its terminal pattern
         assign carry[i] = carry[i-1] & at[i-1];

         // R4
         carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!load && !at[i-1]) |=> $stable(seg_q[i]));
      end

      lfsr_seg #(
         .SEG_W (SEG_W),
         .TAP   (TAP),
         .WRAP  (WRAP_PAT)
      ) u_seg (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_i    (load),
         .pre_i     (preload[i*SEG_W +: SEG_W]),
         .adv_i     (carry[i]),
         .state_o   (seg_q[i]),
         .at_wrap_o (at[i])
      );
   end

   assign term = &at;

   tmr_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .en_i   (en),
      .term_i (term),
      .step_o (step),
      .done_o (done)
   );

   // R8
   term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !load) |=> $stable(seg_q[0]));

endmodule

// File: tb/seg_lfsr_timer_bench.sv
`timescale 1ns/1ps
module seg_lfsr_timer_bench;

   localparam int SW = 5;
   localparam int ST = 3;
   localparam int SP = 31;
   localparam int BW = 18;
   localparam int BT = 11;

   // reverse steps on lower (a), on upper (b), expected cycles a+31*b+1
   localparam int TV [8][3] = '{
      '{3, 0, 4}, '{0, 1, 32}, '{5, 1, 37}, '{1, 2, 64},
      '{30, 0, 31}, '{0, 0, 1}, '{7, 3, 101}, '{30, 30, 961}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_s = 1'b0, en_s = 1'b0, dn_s;
   logic [2*SW-1:0] pre_s = '0;
   logic ld_b = 1'b0, en_b = 1'b0, dn_b;
   logic [2*BW-1:0] pre_b = '0;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   seg_lfsr_timer #(.SEG_W(SW), .SEG_NUM(2), .TAP(ST), .WRAP_PAT(5'h01)) u_seg_lfsr_timer_small (
      .clk(clk), .rst_n(rst_n), .load(ld_s), .preload(pre_s), .en(en_s), .done(dn_s));

   seg_lfsr_timer u_seg_lfsr_timer (
      .clk(clk), .rst_n(rst_n), .load(ld_b), .preload(pre_b), .en(en_b), .done(dn_b));

   function automatic logic [31:0] back_n(input int w, input int tap, input logic [31:0] s, input int n);
      logic [31:0] v;
      v = s;
      for (int i = 0; i < n; i++)
         v = (v >> 1) | (32'(v[0] ^ v[tap]) << (w - 1));
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_done(input bit big, input int limit, output int cyc);
      cyc = 0;
      for (int c = 1; c <= limit; c++) begin
         @(negedge clk);
         if (big ? dn_b : dn_s) begin
            cyc = c;
            break;
         end
      end
   endtask

   function automatic logic [2*SW-1:0] small_pre(input int a, input int b);
      logic [31:0] lo, hi;
      lo = back_n(SW, ST, 32'd1, a);
      hi = back_n(SW, ST, 32'd1, b);
      return {hi[SW-1:0], lo[SW-1:0]};
   endfunction

   function automatic logic [2*BW-1:0] big_pre(input int a);
      logic [31:0] lo;
      lo = back_n(BW, BT, 32'd1, a);
      return {BW'(1), lo[BW-1:0]};
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int cyc;
      int seen;
      repeat (3) @(negedge clk);
      chk(dn_s == 1'b0 && dn_b == 1'b0, "R1 done during reset", int'(dn_s | dn_b), 0);
      rst_n = 1'b1;
      en_s = 1'b1;
      en_b = 1'b1;
      // R1: idle after reset, no load
      seen = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         if (dn_s || dn_b) seen++;
      end
      chk(seen == 0, "R1 idle after reset", seen, 0);

      // R4 R5 R3 R10: table walked back to back on small instance
      for (int t = 0; t < 8; t++) begin
         ld_s = 1'b1;
         pre_s = small_pre(TV[t][0], TV[t][1]);
         @(negedge clk);
         ld_s = 1'b0;
         wait_done(1'b0, 2000, cyc);
         chk(cyc == TV[t][2], $sformatf("R4 R5 R10 vector %0d", t), cyc, TV[t][2]);
      end

      // R6: pulse width
      @(negedge clk);
      chk(dn_s == 1'b0, "R6 pulse one cycle", int'(dn_s), 0);

      // R8: held after done
      seen = 0;
      for (int c = 0; c < 50; c++) begin
         @(negedge clk);
         if (dn_s) seen++;
      end
      chk(seen == 0, "R8 hold after done", seen, 0);

      // R2: default 18-bit segment, taps 18 and 11
      ld_b = 1'b1;
      pre_b = big_pre(10);
      @(negedge clk);
      ld_b = 1'b0;
      wait_done(1'b1, 100, cyc);
      chk(cyc == 11, "R2 R5 wide segment k=10", cyc, 11);
      ld_b = 1'b1;
      pre_b = big_pre(1);
      @(negedge clk);
      ld_b = 1'b0;
      wait_done(1'b1, 100, cyc);
      chk(cyc == 2, "R2 R5 wide segment k=1", cyc, 2);

      // R7: three low-enable cycles in mid count
      ld_b = 1'b1;
      pre_b = big_pre(5);
      @(negedge clk);
      ld_b = 1'b0;
      cyc = 0;
      for (int c = 1; c <= 40; c++) begin
         en_b = !(c >= 3 && c < 6);
         @(negedge clk);
         if (dn_b) begin
            cyc = c;
            break;
         end
      end
      en_b = 1'b1;
      chk(cyc == 9, "R7 enable gaps", cyc, 9);

      // R9: reload in mid count restarts timing
      ld_s = 1'b1;
      pre_s = small_pre(20, 0);
      @(negedge clk);
      ld_s = 1'b0;
      seen = 0;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         if (dn_s) seen++;
      end
      ld_s = 1'b1;
      pre_s = small_pre(3, 0);
      @(negedge clk);
      ld_s = 1'b0;
      chk(seen == 0 && dn_s == 1'b0, "R9 no pulse before reload", seen, 0);
      wait_done(1'b0, 100, cyc);
      chk(cyc == 4, "R9 reload timing", cyc, 4);

      // R9: load on the edge that would set done suppresses it
      ld_s = 1'b1;
      pre_s = small_pre(2, 0);
      @(negedge clk);
      ld_s = 1'b0;
      @(negedge clk);
      @(negedge clk);
      ld_s = 1'b1;
      pre_s = small_pre(4, 0);
      @(negedge clk);
      ld_s = 1'b0;
      chk(dn_s == 1'b0, "R9 suppressed pulse", int'(dn_s), 0);
      wait_done(1'b0, 100, cyc);
      chk(cyc == 5, "R9 timing after suppress", cyc, 5);

      finish_run();
   end

endmodule